// File: doc/BRIEF.md
# Split 32-bit Register Access over a 16-bit Management Bus

This block lets a host reach 32-bit registers inside a switch device that is only reachable through 16-bit clause-22 management transactions. Each host request carries a byte address, write data and a read or write strobe. The block turns it into three transactions, which it hands one at a time to an external management master. It waits for each transaction to complete before it issues the next one.

The first transaction always selects a page by writing the upper half-word address bits to a fixed page register. The other two transactions move the two 16-bit halves. The halves are taken in a fixed order. A read fetches the low half before the high half, so that counters which clear on read stay coherent. A write stores the high half before the low half, so that a start or busy flag held in the low half fires only after the full value is in place.

The assembled read value is presented together with a one-cycle completion pulse. If the management master reports an error on any transaction, the block stops the sequence and flags the error alongside that pulse.

Top module: `split_reg_access`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `err`, `cmd_valid` and `rd_data` are all 0.
- R2: The half-word address is the byte address with its two low bits cleared, shifted right by one. The first command of every access is a write (`cmd_op` = 2'b01) to PHY 0x18, register 0. Its data is half-word address bits 16:8, zero-extended. Byte address bits above 17 have no effect.
- R3: A half-word command targets PHY 0x10 OR half-word address bits 7:5, and register half-word address bits 4:0. The low half uses the even half-word address and the high half uses that address plus one.
- R4: A read issues a read (`cmd_op` = 2'b10) of the low half, then a read of the high half. `rd_data` returns the high result in bits 31:16 and the low result in bits 15:0.
- R5: A write first writes `req_wdata[31:16]` to the high half, then writes `req_wdata[15:0]` to the low half.
- R6: At most one command is outstanding. `cmd_valid` pulses for one cycle per command, and the next pulse follows the `cmd_done` of the previous command. The command fields stay stable while a command is outstanding.
- R7: `done` is high for exactly one cycle, the cycle after the final `cmd_done` is sampled. `req_ready` is high only when no access is in progress.
- R8: A strobe raised while an access is in progress is ignored. The command stream and the result of the access in progress are unchanged, and only one `done` follows.
- R9: If `cmd_err` is high with `cmd_done`, no further command is issued for that access. `done` then pulses in the next cycle with `err` = 1. `err` is never high without `done`.
- R10: When `req_rd` and `req_wr` are both high at acceptance, the access is a write.
- R11: A `cmd_done` pulse while no command is outstanding has no effect. No command and no `done` follow it.
- R12: `rd_data` is cleared to 0 when a request is accepted. It stays 0 through a write and holds the last read value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe, sampled while ready |
| req_wr | input | 1 | Write strobe, sampled while ready |
| req_addr | input | ADDR_W | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | High while idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| rd_data | output | 32 | Assembled read value |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_phy | output | 5 | PHY address of the command |
| cmd_reg | output | 5 | Register number of the command |
| cmd_op | output | 2 | Opcode: 01 write, 10 read |
| cmd_wdata | output | 16 | Write data of the command |
| cmd_done | input | 1 | Command completion pulse from the master |
| cmd_err | input | 1 | Command error, valid with cmd_done |
| cmd_rdata | input | 16 | Read data, valid with cmd_done |

## Verification
A wrong step counter or a wrong latched request shows up at the very next `cmd_valid`, as a wrong PHY, register, opcode or data on the management side. That is one to a few cycles after acceptance, depending on the master's latency. A sequencer that skips its wait or counts completions wrongly shows up as a command issued with another one still outstanding, or as `done` arriving on a cycle other than the one after the final completion. Capture errors surface only at `done`, as swapped or stale halves in `rd_data`. The bench therefore uses distinct data for every PHY and register pair.

// File: rtl/split_reg_pkg.sv
package split_reg_pkg;

    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int PHY_W     = 5;
    localparam int REGN_W    = 5;
    localparam int HW_ADDR_W = 17;
    localparam int PAGE_W    = 9;

    localparam logic [PHY_W-1:0]  PAGE_PHY    = 5'h18;
    localparam logic [REGN_W-1:0] PAGE_REG    = 5'h00;
    localparam logic [1:0]        PORT_PHY_HI = 2'b10;
    localparam logic [1:0]        OP_WR       = 2'b01;
    localparam logic [1:0]        OP_RD       = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_PAGE,
        STEP_FIRST,
        STEP_SECOND
    } step_e;

    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REGN_W-1:0] regn;
        logic [1:0]        op;
        logic [HALF_W-1:0] wdata;
    } mdio_cmd_t;

    typedef struct packed {
        logic                 wr;
        logic [HW_ADDR_W-1:0] hw;
        logic [WORD_W-1:0]    wdata;
    } req_ctx_t;

    // Even half-word address from a byte address (bits 17:0 matter).
    function automatic logic [HW_ADDR_W-1:0] half_addr(input logic [HW_ADDR_W:0] byte_a);
        return {byte_a[HW_ADDR_W:2], 1'b0};
    endfunction

    function automatic mdio_cmd_t half_cmd(input logic [HW_ADDR_W-1:0] hw,
                                           input logic [1:0] op,
                                           input logic [HALF_W-1:0] d);
        mdio_cmd_t c;
        c.phy   = {PORT_PHY_HI, hw[7:5]};
        c.regn  = hw[4:0];
        c.op    = op;
        c.wdata = d;
        return c;
    endfunction

    function automatic mdio_cmd_t page_cmd(input logic [HW_ADDR_W-1:0] hw);
        mdio_cmd_t c;
        c.phy   = PAGE_PHY;
        c.regn  = PAGE_REG;
        c.op    = OP_WR;
        c.wdata = {{(HALF_W-PAGE_W){1'b0}}, hw[HW_ADDR_W-1:HW_ADDR_W-PAGE_W]};
        return c;
    endfunction

endpackage

// File: rtl/sra_cmd_map.sv
module sra_cmd_map
    import split_reg_pkg::*;
(
    input  req_ctx_t  ctx,
    input  step_e     step,
    output mdio_cmd_t cmd
);
    logic [HW_ADDR_W-1:0] hw_lo;
    logic [HW_ADDR_W-1:0] hw_hi;

    assign hw_lo = ctx.hw;
    assign hw_hi = {ctx.hw[HW_ADDR_W-1:1], 1'b1};

    always_comb begin
        case (step)
            STEP_FIRST:
                cmd = ctx.wr ? half_cmd(hw_hi, OP_WR, ctx.wdata[WORD_W-1:HALF_W])
                             : half_cmd(hw_lo, OP_RD, '0);
            STEP_SECOND:
                cmd = ctx.wr ? half_cmd(hw_lo, OP_WR, ctx.wdata[HALF_W-1:0])
                             : half_cmd(hw_hi, OP_RD, '0);
            default:
                cmd = page_cmd(ctx.hw);
        endcase
    end
endmodule

// File: rtl/sra_seq_fsm.sv
module sra_seq_fsm
    import split_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  cmd_done,
    input  logic  cmd_err,
    output step_e step,
    output logic  ready,
    output logic  issue,
    output logic  finish,
    output logic  abort,
    output logic  step_ok
);
    seq_state_e state;
    logic       err_q;

    assign ready   = (state == ST_IDLE);
    assign issue   = (state == ST_ISSUE);
    assign finish  = (state == ST_FINISH);
    assign abort   = finish && err_q;
    assign step_ok = (state == ST_WAIT) && cmd_done && !cmd_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= STEP_PAGE;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    err_q <= 1'b0;
                    if (start) begin
                        step  <= STEP_PAGE;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (cmd_done) begin
                        if (cmd_err) begin
                            err_q <= 1'b1;
                            state <= ST_FINISH;
                        end else if (step == STEP_SECOND) begin
                            state <= ST_FINISH;
                        end else begin
                            step  <= step_e'(step + 2'd1);
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sra_rd_collect.sv
module sra_rd_collect
    import split_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [HALF_W-1:0] half_in,
    output logic [WORD_W-1:0] word_out
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word_out <= '0;
        end else begin
            if (cap_lo) word_out[HALF_W-1:0]      <= half_in;
            if (cap_hi) word_out[WORD_W-1:HALF_W] <= half_in;
        end
    end
endmodule

// File: rtl/split_reg_access.sv
module split_reg_access
    import split_reg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              err,
    output logic [31:0]       rd_data,
    output logic              cmd_valid,
    output logic [4:0]        cmd_phy,
    output logic [4:0]        cmd_reg,
    output logic [1:0]        cmd_op,
    output logic [15:0]       cmd_wdata,
    input  logic              cmd_done,
    input  logic              cmd_err,
    input  logic [15:0]       cmd_rdata
);
    localparam int USED_A = HW_ADDR_W + 1;

    req_ctx_t  ctx;
    mdio_cmd_t cmd;
    step_e     step;
    logic      start, step_ok;
    logic      cap_lo, cap_hi;
    logic [USED_A-1:0] addr_used;

    generate
        if (ADDR_W >= USED_A) begin : g_wide
            assign addr_used = req_addr[USED_A-1:0];
        end else begin : g_narrow
            assign addr_used = {{(USED_A-ADDR_W){1'b0}}, req_addr};
        end
    endgenerate

    assign start = req_ready && (req_rd || req_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (start) begin
            ctx.wr    <= req_wr;
            ctx.hw    <= half_addr(addr_used);
            ctx.wdata <= req_wdata;
        end
    end

    sra_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_done (cmd_done),
        .cmd_err  (cmd_err),
        .step     (step),
        .ready    (req_ready),
        .issue    (cmd_valid),
        .finish   (done),
        .abort    (err),
        .step_ok  (step_ok)
    );

    sra_cmd_map u_map (
        .ctx  (ctx),
        .step (step),
        .cmd  (cmd)
    );

    assign cmd_phy   = cmd.phy;
    assign cmd_reg   = cmd.regn;
    assign cmd_op    = cmd.op;
    assign cmd_wdata = cmd.wdata;

    assign cap_lo = step_ok && !ctx.wr && (step == STEP_FIRST);
    assign cap_hi = step_ok && !ctx.wr && (step == STEP_SECOND);

    sra_rd_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .half_in  (cmd_rdata),
        .word_out (rd_data)
    );
endmodule

// File: rtl/split_reg_access_chk.sv
module split_reg_access_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_rd,
    input logic       req_wr,
    input logic       req_ready,
    input logic       done,
    input logic       err,
    input logic       cmd_valid,
    input logic [4:0] cmd_phy,
    input logic [4:0] cmd_reg,
    input logic [1:0] cmd_op,
    input logic [15:0] cmd_wdata,
    input logic       cmd_done
);
    logic outstanding;
    logic accepted;

    assign accepted = req_ready && (req_rd || req_wr);

    always_ff @(posedge clk) begin
        if (rst)            outstanding <= 1'b0;
        else if (cmd_valid) outstanding <= 1'b1;
        else if (cmd_done)  outstanding <= 1'b0;
    end

    // R6
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !outstanding);

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (outstanding && !cmd_valid) |-> $stable({cmd_phy, cmd_reg, cmd_op, cmd_wdata}));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || done) |-> !req_ready);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R2
    page_first_chk: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (cmd_valid && cmd_phy == 5'h18 && cmd_reg == 5'h00 && cmd_op == 2'b01));

    // R3
    port_phy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_phy != 5'h18) |-> (cmd_phy[4:3] == 2'b10));

    // R11
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && cmd_done && !accepted) |=> (!cmd_valid && !done));
endmodule

bind split_reg_access split_reg_access_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .cmd_valid (cmd_valid),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .cmd_done  (cmd_done)
);

// File: tb/split_reg_access_bench.sv
`timescale 1ns/1ps
module split_reg_access_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, done, err, cmd_valid;
    logic [31:0] rd_data;
    logic [4:0]  cmd_phy, cmd_reg;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_wdata;
    logic        resp_done = 1'b0, spur_done = 1'b0, resp_err = 1'b0;
    logic [15:0] resp_rdata = '0;
    logic        cmd_done;

    int tests = 0, fails = 0, cyc = 0;
    int err_at = -1;
    int last_resp_cyc = 0;
    int q_phy[$], q_reg[$], q_op[$], q_dat[$];
    bit pending = 0;
    int cnt = 0, ncmd = 0;
    bit prev_done = 0;

    assign cmd_done = resp_done | spur_done;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    split_reg_access u_split_reg_access (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .err(err), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_err(resp_err),
        .cmd_rdata(resp_rdata)
    );

    function automatic logic [15:0] fake_rd(input int phy, input int rg);
        return {3'b101, phy[4:0], rg[4:0], 3'b011};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Management-side model: records commands, answers after a varying latency.
    always @(negedge clk) begin
        resp_done = 1'b0;
        resp_err  = 1'b0;
        if (rst) begin
            pending = 0;
        end else begin
            if (pending && cmd_valid)
                check(0, "R6", "command issued while outstanding", 1, 0);
            if (done && prev_done)
                check(0, "R7", "done longer than one cycle", 1, 0);
            if (err && !done)
                check(0, "R9", "err without done", 1, 0);
            prev_done = done;
            if (pending) begin
                cnt--;
                if (cnt == 0) begin
                    resp_done  = 1'b1;
                    resp_rdata = fake_rd(q_phy[$], q_reg[$]);
                    resp_err   = ((q_phy.size() - 1) == err_at);
                    last_resp_cyc = cyc;
                    pending = 0;
                end
            end else if (cmd_valid) begin
                q_phy.push_back(int'(cmd_phy));
                q_reg.push_back(int'(cmd_reg));
                q_op.push_back(int'(cmd_op));
                q_dat.push_back(int'(cmd_wdata));
                ncmd++;
                pending = 1;
                cnt = 1 + (ncmd % 3);
            end
        end
    end

    task automatic access(input bit wr, input bit rd, input logic [31:0] addr,
                          input logic [31:0] wd, input int e_at, input bit poke);
        int hw, n_exp, lo_phy, lo_reg, hi_phy, hi_reg;
        int e_phy[3], e_reg[3], e_op[3], e_dat[3];
        bit got;
        bit eff_wr;
        eff_wr = wr;   // R10: write wins when both strobes are high
        hw     = int'((addr[17:0] & 18'h3FFFC) >> 1);
        lo_phy = 16 | ((hw >> 5) & 7);  lo_reg = hw & 31;
        hi_phy = 16 | (((hw + 1) >> 5) & 7); hi_reg = (hw + 1) & 31;
        e_phy[0] = 24; e_reg[0] = 0; e_op[0] = 1; e_dat[0] = (hw >> 8) & 9'h1FF;
        if (eff_wr) begin
            e_phy[1] = hi_phy; e_reg[1] = hi_reg; e_op[1] = 1; e_dat[1] = int'(wd[31:16]);
            e_phy[2] = lo_phy; e_reg[2] = lo_reg; e_op[2] = 1; e_dat[2] = int'(wd[15:0]);
        end else begin
            e_phy[1] = lo_phy; e_reg[1] = lo_reg; e_op[1] = 2; e_dat[1] = 0;
            e_phy[2] = hi_phy; e_reg[2] = hi_reg; e_op[2] = 2; e_dat[2] = 0;
        end
        n_exp = (e_at >= 0) ? e_at + 1 : 3;
        q_phy.delete(); q_reg.delete(); q_op.delete(); q_dat.delete();
        err_at = e_at;
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_rd = 0; req_wr = 0;
        check(req_ready == 0, "R7", "ready while busy", req_ready, 0);
        check(rd_data == 0, "R12", "rd_data cleared on accept", rd_data, 0);
        if (poke) begin
            req_wr = 1; req_rd = 1; req_addr = ~addr; req_wdata = ~wd;
            @(negedge clk);
            req_wr = 0; req_rd = 0;
        end
        got = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check(got, "R7", "done seen", got, 1);
        check(cyc == last_resp_cyc + 1, "R7", "done one cycle after last completion",
              cyc, last_resp_cyc + 1);
        check(err == (e_at >= 0), "R9", "err flag", err, (e_at >= 0));
        check(q_phy.size() == n_exp, (e_at >= 0) ? "R9" : "R8", "command count",
              q_phy.size(), n_exp);
        for (int k = 0; k < n_exp && k < q_phy.size(); k++) begin
            check(q_phy[k] == e_phy[k], k == 0 ? "R2" : "R3", "phy", q_phy[k], e_phy[k]);
            check(q_reg[k] == e_reg[k], k == 0 ? "R2" : "R3", "reg", q_reg[k], e_reg[k]);
            check(q_op[k] == e_op[k], eff_wr ? "R5" : "R4", "opcode", q_op[k], e_op[k]);
            check(q_dat[k] == e_dat[k], k == 0 ? "R2" : "R5", "cmd data", q_dat[k], e_dat[k]);
        end
        if (e_at < 0 && !eff_wr)
            check(rd_data == {fake_rd(hi_phy, hi_reg), fake_rd(lo_phy, lo_reg)}, "R4",
                  "read result", rd_data, {fake_rd(hi_phy, hi_reg), fake_rd(lo_phy, lo_reg)});
        if (eff_wr)
            check(rd_data == 0, "R12", "rd_data zero after write", rd_data, 0);
        @(negedge clk);
        check(done == 0 && cmd_valid == 0, "R7", "done dropped", done, 0);
        check(req_ready == 1, "R7", "ready after done", req_ready, 1);
        err_at = -1;
    endtask

    initial begin
        #(20 * 150000);
        check(0, "WDOG", "watchdog expired", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1, "R1", "ready", req_ready, 1);
        check(done == 0 && err == 0, "R1", "done/err", {done, err}, 0);
        check(cmd_valid == 0, "R1", "cmd_valid", cmd_valid, 0);
        check(rd_data == 0, "R1", "rd_data", rd_data, 0);

        access(0, 1, 32'h0000_0010, 0, -1, 0);            // R4 basic read
        access(0, 1, 32'h0003_FFFC, 0, -1, 0);            // R2 R3 top of page range
        access(0, 1, 32'h0000_0667, 0, -1, 0);            // R2 low bits cleared
        access(0, 1, 32'hFFFC_0040, 0, -1, 0);            // R2 high bits ignored
        access(1, 0, 32'h0000_0620, 32'hDEAD_BEEF, -1, 0);// R5 write order
        access(1, 0, 32'h0001_2344, 32'h1234_5678, -1, 1);// R8 poke while busy
        access(0, 1, 32'h0000_0F00, 0, -1, 1);            // R8 poke during read
        access(1, 1, 32'h0000_0100, 32'hA5A5_5A5A, -1, 0);// R10 both strobes
        access(0, 1, 32'h0000_0200, 0, 0, 0);             // R9 error on page step
        access(1, 0, 32'h0000_0300, 32'h0BAD_F00D, 1, 0); // R9 error on first half
        access(0, 1, 32'h0000_0400, 0, 2, 0);             // R9 error on second half

        // R12 read value held while idle
        access(0, 1, 32'h0000_0088, 0, -1, 0);
        held = rd_data;
        repeat (3) @(negedge clk);
        check(rd_data == held, "R12", "rd_data held while idle", rd_data, held);

        // R11 stray completion while idle
        ncmd = 0;
        spur_done = 1;
        @(negedge clk);
        spur_done = 0;
        for (int i = 0; i < 4; i++) begin
            check(cmd_valid == 0 && done == 0, "R11", "no activity after stray done",
                  {cmd_valid, done}, 0);
            @(negedge clk);
        end
        check(ncmd == 0, "R11", "no command recorded", ncmd, 0);
        access(0, 1, 32'h0000_0044, 0, -1, 0);            // R11 normal after stray

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule